// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by fetching two entries from a page table held in memory. A requester presents the linear address, the base of the page directory and a paging switch in one cycle. The block takes the top ten address bits as an index into the directory, reads that directory entry, then takes the middle ten bits as an index into the page table the entry names, and reads the table entry. The frame base from that second entry, joined with the twelve-bit offset inside the 4096-byte page, is the physical address.

When the paging switch is off, the linear address comes back unchanged and no memory read is made. When either entry is marked absent, the walk stops, a fault pulse is raised, and the linear address that could not be translated is kept in a status output. The memory side is a single read port: the block holds a read request and its address until the memory signals ready, and the read data is taken in that same cycle.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `done`, `fault`, `mem_rd_req` and `busy` are low and `fault_addr` is zero.
- R2: A request accepted with `paging_on` low returns `phys_addr` equal to `req_vaddr` with no memory read.
- R3: The first read of a walk is addressed at `dir_base + 4 * req_vaddr[31:22]`.
- R4: The second read is addressed at `{dir_entry[31:12], req_vaddr[21:12], 2'b00}`.
- R5: A completed walk gives `phys_addr = {tbl_entry[31:12], req_vaddr[11:0]}` together with a one-cycle `done` pulse.
- R6: A directory entry with bit 0 (present) clear raises `fault` and no second read is made.
- R7: A table entry with bit 0 (present) clear raises `fault` instead of `done`.
- R8: On a fault, `fault_addr` takes the linear address being walked, keeps it while idle, and returns to zero when the next request is accepted.
- R9: While `mem_rd_ready` is low, `mem_rd_req` stays high and `mem_rd_addr` keeps its value.
- R10: `req_valid` is taken only while `busy` is low; a request presented during a walk has no effect on it, and inputs changed after acceptance do not alter the result.
- R11: Counting clock edges after the accepting edge, `done` is visible after 0 edges without paging; a walk ends after 2 + w1 + w2 edges, or 1 + w1 on a directory fault, where w1 and w2 are the low cycles of `mem_rd_ready` for each read.
- R12: `done` and `fault` are never high together and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Byte address of the page directory |
| paging_on | input | 1 | High: walk the tables; low: pass the address through |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_ready | input | 1 | Memory has placed the entry on `mem_rd_data` |
| mem_rd_data | input | 32 | Entry read from memory |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle pulse: `phys_addr` is valid |
| phys_addr | output | 32 | Translated address |
| fault | output | 1 | One-cycle pulse: a page was absent |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
Each result is due at a fixed edge count after the accepting edge: none for pass-through, one plus the directory wait for a directory fault, and two plus both waits for a finished walk. The bench plays the memory itself, adding the programmed wait before each ready, counts edges from acceptance at every falling edge, and compares the edge on which `done` or `fault` shows against that formula. Read addresses are checked when each read first appears and again on every wait cycle, and one edge after a result it confirms that both pulses are low.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker.
// Assumes entries are four bytes, so a page holds exactly one table.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DIR   = 3'd1,
        ST_TBL   = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } walk_state_e;

    localparam int ENTRY_BYTES_LOG2 = 2;

endpackage

// File: rtl/ptw_fsm.sv
// Walk sequencer: idle, directory read, table read, then done or fault.
// Assumes read data is valid in the cycle mem_rd_ready is high.
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        paging_on,
    input  logic        mem_rd_ready,
    input  logic        entry_present,
    output walk_state_e state,
    output logic        accept,
    output logic        dir_take,
    output logic        tbl_take,
    output logic        go_fault
);

    walk_state_e state_nxt;
    logic        reading;

    // Decode the handshake events of the current state.
    always_comb begin
        reading  = (state == ST_DIR) || (state == ST_TBL);
        accept   = (state == ST_IDLE) && req_valid;
        dir_take = (state == ST_DIR) && mem_rd_ready && entry_present;
        tbl_take = (state == ST_TBL) && mem_rd_ready && entry_present;
        go_fault = reading && mem_rd_ready && !entry_present;
    end

    // Choose the next walk state.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nxt = paging_on ? ST_DIR : ST_DONE;
                end
            end
            ST_DIR: begin
                if (go_fault) begin
                    state_nxt = ST_FAULT;
                end else if (dir_take) begin
                    state_nxt = ST_TBL;
                end
            end
            ST_TBL: begin
                if (go_fault) begin
                    state_nxt = ST_FAULT;
                end else if (tbl_take) begin
                    state_nxt = ST_DONE;
                end
            end
            ST_DONE:  state_nxt = ST_IDLE;
            ST_FAULT: state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/ptw_addr_gen.sv
// Holds the captured request and builds entry and physical addresses.
// Assumes VA_W = 3*IDX_W + 2 so the offset field is IDX_W + 2 bits.
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int VA_W  = 3 * IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  walk_state_e       state,
    input  logic              accept,
    input  logic              dir_take,
    input  logic              tbl_take,
    input  logic              paging_on,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [VA_W-1:0]   dir_base,
    input  logic [VA_W-1:0]   rd_data,
    output logic [VA_W-1:0]   rd_addr,
    output logic [VA_W-1:0]   va_held,
    output logic [VA_W-1:0]   phys_addr
);

    localparam int OFF_W  = IDX_W + ENTRY_BYTES_LOG2;
    localparam int BASE_W = VA_W - OFF_W;
    localparam int PAD_W  = VA_W - IDX_W - ENTRY_BYTES_LOG2;

    logic [VA_W-1:0]   va_q;
    logic [VA_W-1:0]   base_q;
    logic [BASE_W-1:0] tbl_base_q;
    logic [VA_W-1:0]   phys_q;
    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  tbl_idx;
    logic [VA_W-1:0]   dir_addr;
    logic [VA_W-1:0]   tbl_addr;

    // Split the held linear address into its two indices.
    always_comb begin
        dir_idx = va_q[VA_W-1 -: IDX_W];
        tbl_idx = va_q[OFF_W +: IDX_W];
    end

    // Entry addresses: directory base plus scaled index; table base joined with index.
    always_comb begin
        dir_addr = base_q + {{PAD_W{1'b0}}, dir_idx, {ENTRY_BYTES_LOG2{1'b0}}};
        tbl_addr = {tbl_base_q, tbl_idx, {ENTRY_BYTES_LOG2{1'b0}}};
        rd_addr  = (state == ST_TBL) ? tbl_addr : dir_addr;
    end

    // Capture the request, the table base and the final frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q       <= '0;
            base_q     <= '0;
            tbl_base_q <= '0;
            phys_q     <= '0;
        end else begin
            if (accept) begin
                va_q   <= req_vaddr;
                base_q <= dir_base;
                if (!paging_on) begin
                    phys_q <= req_vaddr;
                end
            end
            if (dir_take) begin
                tbl_base_q <= rd_data[VA_W-1:OFF_W];
            end
            if (tbl_take) begin
                phys_q <= {rd_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
            end
        end
    end

    assign va_held   = va_q;
    assign phys_addr = phys_q;

endmodule

// File: rtl/ptw_fault_reg.sv
// Status register for the linear address of the most recent fault.
// Assumes go_fault and accept never occur in the same cycle.
module ptw_fault_reg #(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_fault,
    input  logic            accept,
    input  logic [VA_W-1:0] va_held,
    output logic [VA_W-1:0] fault_addr
);

    // Latch on fault, clear when the next request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
        end else if (go_fault) begin
            fault_addr <= va_held;
        end else if (accept) begin
            fault_addr <= '0;
        end
    end

endmodule

// File: rtl/ptw_walker.sv
// Top of the two-level page table walker.
// Assumes one outstanding memory read and four-byte entries with present in bit 0.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int VA_W  = 3 * IDX_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] dir_base,
    input  logic            paging_on,
    output logic            mem_rd_req,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_ready,
    input  logic [VA_W-1:0] mem_rd_data,
    output logic            busy,
    output logic            done,
    output logic [VA_W-1:0] phys_addr,
    output logic            fault,
    output logic [VA_W-1:0] fault_addr
);

    walk_state_e     state;
    logic            accept;
    logic            dir_take;
    logic            tbl_take;
    logic            go_fault;
    logic [VA_W-1:0] va_held;

    ptw_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .paging_on     (paging_on),
        .mem_rd_ready  (mem_rd_ready),
        .entry_present (mem_rd_data[0]),
        .state         (state),
        .accept        (accept),
        .dir_take      (dir_take),
        .tbl_take      (tbl_take),
        .go_fault      (go_fault)
    );

    ptw_addr_gen #(.IDX_W(IDX_W), .VA_W(VA_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .dir_take  (dir_take),
        .tbl_take  (tbl_take),
        .paging_on (paging_on),
        .req_vaddr (req_vaddr),
        .dir_base  (dir_base),
        .rd_data   (mem_rd_data),
        .rd_addr   (mem_rd_addr),
        .va_held   (va_held),
        .phys_addr (phys_addr)
    );

    ptw_fault_reg #(.VA_W(VA_W)) u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_fault   (go_fault),
        .accept     (accept),
        .va_held    (va_held),
        .fault_addr (fault_addr)
    );

    // Status outputs decoded from the walk state.
    always_comb begin
        busy       = (state != ST_IDLE);
        mem_rd_req = (state == ST_DIR) || (state == ST_TBL);
        done       = (state == ST_DONE);
        fault      = (state == ST_FAULT);
    end

endmodule

// File: rtl/ptw_walker_chk.sv
// Protocol and pulse checks for ptw_walker, attached by bind.
module ptw_walker_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            mem_rd_req,
    input logic [VA_W-1:0] mem_rd_addr,
    input logic            mem_rd_ready,
    input logic            busy,
    input logic            done,
    input logic            fault,
    input logic [VA_W-1:0] fault_addr
);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ready) |=> (mem_rd_req && $stable(mem_rd_addr))); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault); // R12
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R12
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_req); // R2
    AST_IDLE_TAKES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy); // R10
    AST_FAULT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_addr != $past(fault_addr)) |-> (fault || $past(req_valid && !busy))); // R8

endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W)) u_ptw_walker_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .busy         (busy),
    .done         (done),
    .fault        (fault),
    .fault_addr   (fault_addr)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;

    typedef struct packed {
        logic        pg;
        logic [31:0] va;
        logic [31:0] base;
        logic [31:0] pde;
        logic [31:0] pte;
        logic [3:0]  w1;
        logic [3:0]  w2;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b0, 32'h1234_5678, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 4'd0, 4'd0},
        '{1'b1, 32'h0040_3ABC, 32'h0010_0000, 32'h0020_0001, 32'h0ABC_D003, 4'd0, 4'd0},
        '{1'b1, 32'hFFFF_FFFF, 32'h0000_5000, 32'hFFFF_F001, 32'h1234_5001, 4'd2, 4'd3},
        '{1'b1, 32'h0000_0000, 32'hABCD_E000, 32'h0000_1001, 32'h0000_0001, 4'd1, 4'd0},
        '{1'b1, 32'h8765_4321, 32'h0003_0000, 32'h0004_0000, 32'h0009_0001, 4'd1, 4'd0},
        '{1'b1, 32'h1357_9BDF, 32'h0006_0000, 32'h0007_0FFF, 32'h0008_0FFE, 4'd0, 4'd2},
        '{1'b1, 32'h0080_0000, 32'h0000_0104, 32'h0000_2001, 32'hCAFE_B001, 4'd0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] dir_base = '0;
    logic        paging_on = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        busy;
    logic        done;
    logic [31:0] phys_addr;
    logic        fault;
    logic [31:0] fault_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit all_done = 1'b0;

    always #10 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .dir_base     (dir_base),
        .paging_on    (paging_on),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .busy         (busy),
        .done         (done),
        .phys_addr    (phys_addr),
        .fault        (fault),
        .fault_addr   (fault_addr)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one request, act as memory, and check addresses, result and timing.
    task automatic run_walk(input vec_t v, input bit poke);
        logic [31:0] exp_dir, exp_tbl, exp_phys, want_addr;
        bit exp_fault, fin, served;
        int exp_lat, edges, level, waited;
        exp_dir   = v.base + {20'd0, v.va[31:22], 2'b00};
        exp_tbl   = {v.pde[31:12], v.va[21:12], 2'b00};
        exp_fault = v.pg && (!v.pde[0] || !v.pte[0]);
        exp_phys  = v.pg ? {v.pte[31:12], v.va[11:0]} : v.va;
        exp_lat   = !v.pg ? 0 : (!v.pde[0] ? 1 + int'(v.w1) : 2 + int'(v.w1) + int'(v.w2));
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v.va; dir_base = v.base; paging_on = v.pg;
        @(posedge clk);
        @(negedge clk);
        // R10: inputs changed after acceptance must not matter
        req_valid = 1'b0; req_vaddr = ~v.va; dir_base = ~v.base; paging_on = ~v.pg;
        edges = 0; level = 0; waited = 0; fin = 1'b0;
        while (!fin && edges < 64) begin
            served = 1'b0;
            if (done || fault) begin
                fin = 1'b1;
                check(fault == exp_fault, exp_fault ? (!v.pde[0] ? "R6" : "R7") : (v.pg ? "R5" : "R2"),
                      {31'd0, fault}, {31'd0, exp_fault});
                if (!exp_fault) begin
                    check(phys_addr == exp_phys, v.pg ? "R5" : "R2", phys_addr, exp_phys);
                end else begin
                    check(fault_addr == v.va, "R8", fault_addr, v.va);
                end
                check(edges == exp_lat, "R11", edges, exp_lat);
            end else if (mem_rd_req) begin
                want_addr = (level == 0) ? exp_dir : exp_tbl;
                if (waited == 0) begin
                    check(mem_rd_addr == want_addr, (level == 0) ? "R3" : "R4", mem_rd_addr, want_addr);
                end else begin
                    check(mem_rd_addr == want_addr, "R9", mem_rd_addr, want_addr);
                end
                if (waited == ((level == 0) ? int'(v.w1) : int'(v.w2))) begin
                    mem_rd_ready = 1'b1;
                    mem_rd_data  = (level == 0) ? v.pde : v.pte;
                    served = 1'b1;
                end else begin
                    waited++;
                end
            end
            if (!fin) begin
                req_valid = poke;
                if (poke) begin
                    req_vaddr = 32'hDEAD_0000; paging_on = 1'b0;
                end
                @(posedge clk);
                edges++;
                @(negedge clk);
                mem_rd_ready = 1'b0; mem_rd_data = 32'h0;
                if (served) begin
                    level++; waited = 0;
                end
            end
        end
        if (!fin) check(1'b0, "R11", edges, exp_lat);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!done && !fault, "R12", {30'd0, done, fault}, 32'd0);
        check(!busy, "R12", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!done && !fault && !mem_rd_req && !busy, "R1",
              {28'd0, done, fault, mem_rd_req, busy}, 32'd0);
        check(fault_addr == 32'd0, "R1", fault_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1", {31'd0, busy}, 32'd0);

        // Table of vectors covering R2 to R7 and R11
        for (int i = 0; i < NVEC; i++) begin
            run_walk(VECS[i], 1'b0);
        end

        // R8: fault address held while idle, then cleared on the next request
        run_walk(VECS[4], 1'b0);
        repeat (5) @(negedge clk);
        check(fault_addr == VECS[4].va, "R8", fault_addr, VECS[4].va);
        run_walk(VECS[0], 1'b0);
        check(fault_addr == 32'd0, "R8", fault_addr, 32'd0);

        // R10: a request presented mid-walk is ignored
        run_walk(VECS[2], 1'b1);
        run_walk(VECS[5], 1'b1);

        all_done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule